// File: doc/BRIEF.md
# Access Pacing and Wake Controller

This block decides when the transaction sequencer of a serial peripheral port may begin its next bus transaction. It holds each new transaction back until a minimum quiet time has passed since the previous one ended. If a ready interrupt from the device has been shown to work, the quiet time instead ends on the interrupt's rising edge, with a longer timeout as a fallback. When the bus has been quiet long enough that the device may have gone to sleep, the block first drives a chip-select wake pulse with no clocks, then waits for the device to start up, and only then grants the transaction.

The controller starts in a confirming mode. Each access made in that mode is one attempt to see a ready edge. One edge moves it to interrupt pacing. If the attempt budget runs out with no edge, it falls back to fixed-delay pacing for good. All long intervals are measured on one free-running millisecond tick counter, and every comparison is done as a modular difference, so counter wrap does no harm. The sequencer strobes the arm input just before each data phase, reports the end of every transaction (successful or not), and strobes resume after a system wake-up.

Top module: `pace_wake_ctrl`

## Requirements
- R1: After reset grant_o and cs_wake_o are 0, mode_o is 0 (confirming) and tmo_cnt_o is 0.
- R2: In fixed-delay mode (mode_o = 2), a grant comes between GAP_MS-1 and GAP_MS milliseconds (plus a few cycles) after the previous transaction end. Ready edges have no effect on it.
- R3: In confirming mode, a ready rising edge seen before a pacing wait finishes moves mode_o to 1 (interrupt) at that wait's end. The wait itself ends early on that edge.
- R4: In confirming mode, when MAX_TRIES pacing waits have finished with no ready edge ever seen, mode_o becomes 2 at the end of the last one and stays 2 until reset. After MAX_TRIES-1 such waits it is still 0.
- R5: In interrupt mode, a pending ready edge gives a grant within 4 cycles of the request. With no pending edge, the grant comes between IRQ_TMO_MS-1 and IRQ_TMO_MS ms after the previous end, and tmo_cnt_o goes up by exactly one.
- R6: When a request finds the sleep deadline reached (SLEEP_MS ticks after the previous grant), cs_wake_o is high for exactly WAKE_MS*CYC_PER_MS cycles. It is then low for exactly START_MS*CYC_PER_MS cycles before grant_o, and it is never high together with grant_o.
- R7: A resume strobe makes the next access perform a wake pulse, even when that access follows right after another one.
- R8: The first access after reset performs a wake pulse.
- R9: A ready edge that arrives before the arm strobe of a transaction is discarded. In interrupt mode the next access then waits for the full timeout.
- R10: An access that starts within the sleep window of the previous grant produces no wake pulse.
- R11: grant_o is a one-cycle pulse. No further grant is given until xfer_end_i has been seen, even while req_i stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Sequencer wants to start a transaction |
| grant_o | output | 1 | One-cycle permission to start the transaction |
| cs_wake_o | output | 1 | Forces chip select active for the wake pulse |
| rdy_irq_i | input | 1 | Device ready interrupt, rising-edge significant |
| arm_i | input | 1 | Strobe just before the data phase; discards earlier ready edges |
| xfer_end_i | input | 1 | Strobe at the end of every transaction, successful or not |
| resume_i | input | 1 | Strobe after a system wake-up; forces a wake on the next access |
| mode_o | output | 2 | Pacing mode: 0 confirming, 1 interrupt, 2 fixed delay |
| tmo_cnt_o | output | CNTW | Saturating count of interrupt-mode pacing timeouts |

## Verification
The hardest case to reach is the move from interrupt pacing to a timed-out wait. It needs an earlier transaction in which a ready edge arrived only before the arm strobe, so that the stale edge is dropped and the next pacing wait runs its full length. The stimulus table interleaves accesses whose ready pulse comes before or after arm, and checks the wait length and the timeout count after each. A second run from reset withholds every ready edge, so the attempt budget runs out, and then injects an edge in the middle of a fixed-delay gap to show that it is ignored.

// File: rtl/pace_pkg.sv
package pace_pkg;
    typedef enum logic [1:0] {
        MODE_CONFIRM = 2'd0,
        MODE_IRQ     = 2'd1,
        MODE_FIXED   = 2'd2
    } pace_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_WAKE_CS,
        ST_WAKE_START,
        ST_GRANT,
        ST_BUSY
    } pace_state_e;
endpackage

// File: rtl/pace_ms_timer.sv
module pace_ms_timer #(
    parameter int CYC_PER_MS = 100000,
    parameter int TW         = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    output logic [TW-1:0] ms_o
);
    localparam int PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [TW-1:0] ms;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.pre == PW'(CYC_PER_MS - 1)) begin
            t_d.pre = '0;
            t_d.ms  = t_q.ms + 1'b1;
        end else begin
            t_d.pre = t_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    assign ms_o = t_q.ms;

    // Tick counter advances by at most one per cycle (pacing base for R2)
    p_tick_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (t_q.ms != $past(t_q.ms)) |-> (t_q.ms == TW'($past(t_q.ms) + 1'b1)));
endmodule

// File: rtl/pace_edge.sv
module pace_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= prev_d;
    end

    assign rise_o = lvl_i & ~prev_q;

    // A rising edge cannot be reported on two consecutive cycles (R3)
    p_rise_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);
endmodule

// File: rtl/pace_wake_ctrl.sv
module pace_wake_ctrl
    import pace_pkg::*;
#(
    parameter int CYC_PER_MS = 100000,
    parameter int GAP_MS     = 2,
    parameter int IRQ_TMO_MS = 750,
    parameter int SLEEP_MS   = 1000,
    parameter int WAKE_MS    = 1,
    parameter int START_MS   = 1,
    parameter int MAX_TRIES  = 3,
    parameter int TW         = 16,
    parameter int CNTW       = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            req_i,
    output logic            grant_o,
    output logic            cs_wake_o,
    input  logic            rdy_irq_i,
    input  logic            arm_i,
    input  logic            xfer_end_i,
    input  logic            resume_i,
    output logic [1:0]      mode_o,
    output logic [CNTW-1:0] tmo_cnt_o
);
    localparam int WAKE_CYC  = WAKE_MS * CYC_PER_MS;
    localparam int START_CYC = START_MS * CYC_PER_MS;
    localparam int CYC_MAX   = (WAKE_CYC > START_CYC) ? WAKE_CYC : START_CYC;
    localparam int CW        = $clog2(CYC_MAX + 1);
    localparam int AW        = $clog2(MAX_TRIES + 1);

    typedef struct packed {
        pace_state_e     state;
        pace_mode_e      mode;
        logic [AW-1:0]   tries;
        logic            seen;
        logic            confirmed;
        logic            waited;
        logic [TW-1:0]   last;
        logic [TW-1:0]   wake_after;
        logic [CW-1:0]   cnt;
        logic [CNTW-1:0] tmo;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [TW-1:0] ms_now;
    logic          rise;

    pace_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .TW(TW)) u_timer (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ms_o  (ms_now)
    );

    pace_edge u_edge (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .lvl_i (rdy_irq_i),
        .rise_o(rise)
    );

    logic [TW-1:0] elapsed, window, delay;
    logic          need_wake, gap_done;

    always_comb begin
        elapsed   = ms_now - r_q.last;
        window    = r_q.wake_after - r_q.last;
        need_wake = window[TW-1] || (elapsed >= window);
        delay     = (r_q.mode == MODE_IRQ) ? TW'(IRQ_TMO_MS) : TW'(GAP_MS);
        gap_done  = ((r_q.mode != MODE_FIXED) && r_q.seen) || (elapsed >= delay);

        r_d           = r_q;
        r_d.seen      = rise | (r_q.seen & ~arm_i);
        r_d.confirmed = r_q.confirmed | rise;

        unique case (r_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    r_d.state  = ST_GAP;
                    r_d.waited = 1'b0;
                end
            end
            ST_GAP: begin
                if (!gap_done) begin
                    r_d.waited = 1'b1;
                end else begin
                    if (r_q.mode == MODE_CONFIRM) begin
                        if (r_q.confirmed || r_q.seen) begin
                            r_d.mode = MODE_IRQ;
                        end else begin
                            r_d.tries = r_q.tries + 1'b1;
                            if (int'(r_q.tries) + 1 >= MAX_TRIES) r_d.mode = MODE_FIXED;
                        end
                    end else if (r_q.mode == MODE_IRQ && !r_q.seen && r_q.waited
                                 && r_q.tmo != '1) begin
                        r_d.tmo = r_q.tmo + 1'b1;
                    end
                    r_d.cnt   = '0;
                    r_d.state = need_wake ? ST_WAKE_CS : ST_GRANT;
                end
            end
            ST_WAKE_CS: begin
                if (r_q.cnt == CW'(WAKE_CYC - 1)) begin
                    r_d.cnt   = '0;
                    r_d.state = ST_WAKE_START;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_WAKE_START: begin
                if (r_q.cnt == CW'(START_CYC - 1)) begin
                    r_d.cnt   = '0;
                    r_d.state = ST_GRANT;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_GRANT: begin
                r_d.wake_after = ms_now + TW'(SLEEP_MS);
                r_d.state      = ST_BUSY;
            end
            ST_BUSY: begin
                if (xfer_end_i) begin
                    r_d.last  = ms_now;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (resume_i) r_d.wake_after = ms_now;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.mode  <= MODE_CONFIRM;
        end else begin
            r_q <= r_d;
        end
    end

    assign grant_o   = (r_q.state == ST_GRANT);
    assign cs_wake_o = (r_q.state == ST_WAKE_CS);
    assign mode_o    = r_q.mode;
    assign tmo_cnt_o = r_q.tmo;

    // Wake pulse and grant never overlap
    p_wake_no_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_wake_o |-> !grant_o);

    // Grant is a single-cycle pulse
    p_grant_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_o |=> !grant_o);

    // Fixed-delay fallback is permanent
    p_fixed_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == MODE_FIXED) |=> (mode_o == MODE_FIXED));

    // Timeout count only ever steps up by one
    p_tmo_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmo_cnt_o != $past(tmo_cnt_o)) |-> (tmo_cnt_o == CNTW'($past(tmo_cnt_o) + 1'b1)));

    // Interrupt mode is entered only from confirming mode
    p_irq_from_confirm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mode_o == MODE_IRQ) |-> ($past(mode_o) == MODE_CONFIRM));
endmodule

// File: tb/pace_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module pace_wake_ctrl_tb_top;
    localparam int CPM   = 4;
    localparam int GAP   = 2;
    localparam int TMO   = 6;
    localparam int SLP   = 20;
    localparam int WK    = 1;
    localparam int ST    = 1;
    localparam int TRIES = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, rdy = 1'b0, arm = 1'b0, xend = 1'b0, resume = 1'b0;
    logic       grant, cs_wake;
    logic [1:0] mode;
    logic [7:0] tmo;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pace_wake_ctrl #(
        .CYC_PER_MS(CPM), .GAP_MS(GAP), .IRQ_TMO_MS(TMO), .SLEEP_MS(SLP),
        .WAKE_MS(WK), .START_MS(ST), .MAX_TRIES(TRIES), .TW(16), .CNTW(8)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .grant_o(grant),
        .cs_wake_o(cs_wake), .rdy_irq_i(rdy), .arm_i(arm), .xfer_end_i(xend),
        .resume_i(resume), .mode_o(mode), .tmo_cnt_o(tmo)
    );

    typedef struct packed {
        logic   pre;
        logic   post;
        logic   woke;
        logic [1:0] mode;
        logic [7:0] wmin;
        logic [7:0] wmax;
        logic [7:0] tmo;
    } vec_t;

    // Interrupt-pacing sequence run from reset
    localparam vec_t TBL [6] = '{
        '{1'b0, 1'b1, 1'b1, 2'd0, 8'd0,  8'd250, 8'd0},  // R8 first access wakes
        '{1'b0, 1'b1, 1'b0, 2'd1, 8'd0,  8'd4,   8'd0},  // R3 edge confirms
        '{1'b1, 1'b0, 1'b0, 2'd1, 8'd0,  8'd4,   8'd0},  // R5 pending edge, fast
        '{1'b0, 1'b1, 1'b0, 2'd1, 8'd20, 8'd28,  8'd1},  // R9 stale edge dropped
        '{1'b0, 1'b0, 1'b0, 2'd1, 8'd0,  8'd4,   8'd1},  // R5 fast again
        '{1'b0, 1'b1, 1'b0, 2'd1, 8'd20, 8'd28,  8'd2}   // R5 timeout counted
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = 0; rdy = 0; arm = 0; xend = 0; resume = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(grant == 0 && cs_wake == 0, "R1 outputs idle", {grant, cs_wake}, 0);
        chk(mode == 0 && tmo == 0, "R1 mode/count", {mode, tmo}, 0);
    endtask

    task automatic access(input bit gap_irq, input bit pre, input bit post,
                          output int wait_c, output int hi_c, output int lo_c,
                          output bit woke);
        bit got;
        wait_c = 0; hi_c = 0; lo_c = 0; woke = 0; got = 0;
        req = 1'b1;
        while (!got && wait_c < 3000) begin
            @(negedge clk);
            wait_c++;
            rdy = (wait_c == 1) ? gap_irq : 1'b0;
            if (grant) got = 1;
            else if (cs_wake) begin hi_c++; woke = 1; end
            else if (woke) lo_c++;
        end
        rdy = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(grant == 0, "R11 no regrant while busy", grant, 0);
        end
        req = 1'b0;
        if (pre) begin rdy = 1; @(negedge clk); rdy = 0; @(negedge clk); end
        arm = 1; @(negedge clk); arm = 0;
        if (post) begin rdy = 1; @(negedge clk); rdy = 0; @(negedge clk); end
        xend = 1; @(negedge clk); xend = 0;
    endtask

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int w, hi, lo;
        bit wk;

        // ---- interrupt pacing from reset, table driven ----
        do_reset();
        for (int i = 0; i < 6; i++) begin
            access(1'b0, TBL[i].pre, TBL[i].post, w, hi, lo, wk);
            chk(wk == TBL[i].woke, "R8/R10 wake decision", wk, TBL[i].woke);
            chk(mode == TBL[i].mode, "R3 mode after access", mode, TBL[i].mode);
            chk(w >= TBL[i].wmin && w <= TBL[i].wmax, "R5/R9 wait cycles", w, TBL[i].wmin);
            chk(tmo == TBL[i].tmo, "R5 timeout count", tmo, TBL[i].tmo);
        end

        // ---- R6: idle past the sleep deadline ----
        repeat (120) @(negedge clk);
        access(1'b0, 1'b0, 1'b1, w, hi, lo, wk);
        chk(wk == 1, "R6 wake after sleep", wk, 1);
        chk(hi == WK * CPM, "R6 wake pulse length", hi, WK * CPM);
        chk(lo == ST * CPM, "R6 start-up wait", lo, ST * CPM);

        // ---- R10: back-to-back access, no wake ----
        access(1'b0, 1'b0, 1'b1, w, hi, lo, wk);
        chk(wk == 0, "R10 no wake when recent", wk, 0);

        // ---- R7: resume forces wake ----
        resume = 1; @(negedge clk); resume = 0;
        access(1'b0, 1'b0, 1'b1, w, hi, lo, wk);
        chk(wk == 1, "R7 wake after resume", wk, 1);
        chk(hi == WK * CPM, "R7 wake pulse length", hi, WK * CPM);

        // ---- fixed-delay fallback, no ready edges ----
        do_reset();
        access(1'b0, 1'b0, 1'b0, w, hi, lo, wk);
        chk(wk == 1, "R8 first access wakes", wk, 1);
        chk(mode == 0, "R4 still confirming after 1", mode, 0);
        access(1'b0, 1'b0, 1'b0, w, hi, lo, wk);
        chk(mode == 0, "R4 still confirming after 2", mode, 0);
        access(1'b0, 1'b0, 1'b0, w, hi, lo, wk);
        chk(mode == 2, "R4 fixed after budget", mode, 2);
        access(1'b1, 1'b0, 1'b0, w, hi, lo, wk);
        chk(w >= (GAP - 1) * CPM && w <= GAP * CPM + 4, "R2 gap ignores edge", w, GAP * CPM);
        chk(mode == 2, "R4 fixed is sticky", mode, 2);
        access(1'b0, 1'b0, 1'b1, w, hi, lo, wk);
        chk(w >= (GAP - 1) * CPM && w <= GAP * CPM + 4, "R2 fixed gap", w, GAP * CPM);
        chk(mode == 2 && tmo == 0, "R2 no mode change", {mode, tmo}, 8'h0 | (2 << 8));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule